// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps the contents of an asynchronous DRAM alive and brings the device into service after power is applied. A slot timer divides the refresh period into equal intervals. Each slot asks the access controller for the memory bus through a request/grant handshake. Once the grant arrives, the block runs one refresh cycle in which the column strobe falls before the row strobe. In that form of refresh the memory supplies the row from its own internal counter, so the block drives no address and moves no data.

After reset the block counts a programmable power-up pause, then runs a fixed number of wake-up refresh cycles, and only then raises `ready`. Host access requests are accepted only while `ready` is high. Slots that cannot be serviced because the grant is withheld build up a small backlog. When the grant returns, the backlog is drained back to back. If a slot expires while the backlog is already full, the refresh deadline is treated as missed. The block then pulses `deadMiss`, drops `ready`, discards the backlog and repeats the whole wake-up sequence.

All timing is expressed in clock cycles through parameters. The defaults assume a 250 MHz clock, a 200 us pause, 512 slots per 8 ms and 60 ns class strobe minimums.

Top module: `refresh_seq`

## Requirements
- R1: While reset is asserted, `rasN` and `casN` are high and `refReq`, `ready`, `hostOk` and `deadMiss` are low.
- R2: In every refresh cycle `casN` is low and `rasN` high for exactly CSR_CYC cycles before `rasN` falls. `casN` then stays low for exactly CHR_CYC cycles with `rasN` low, and `casN` never falls while `rasN` is low.
- R3: `refReq` stays high from its rise until the refresh cycle ends, whether or not `refGnt` is given. No strobe moves before `refGnt` has been seen high during that request.
- R4: `rasN` stays low for exactly RAS_CYC cycles. Both strobes are then high for at least RP_CYC cycles before `casN` falls again.
- R5: With the grant given at once, `ready` rises exactly PAUSE_CYC + WAKE_NUM*(CSR_CYC+RAS_CYC+RP_CYC+2) cycles after reset release, and exactly WAKE_NUM row-strobe pulses occur before it.
- R6: Once `ready` is high, a slot expires every SLOT_CYC cycles. `refReq` rises SLOT_CYC+1 cycles after `ready` rose (or after the previous slot expired), and each slot produces one refresh.
- R7: Slots missed while the grant is withheld are kept as a backlog of up to BACKLOG_MAX. When the grant returns they run back to back, after which `refReq` falls and `ready` remains high.
- R8: A slot that expires while the backlog already holds BACKLOG_MAX pulses `deadMiss` high for one cycle. `ready` falls in the next cycle, the backlog is cleared, and `ready` returns only after WAKE_NUM further refreshes.
- R9: `hostOk` is high only when `hostReq` is high and `ready` is high.
- R10: The slot timer is held while `ready` is low and restarts from a full slot when `ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refGnt | input | 1 | Bus grant from the access controller |
| hostReq | input | 1 | Host access request to be qualified |
| refReq | output | 1 | Refresh bus request, held until the cycle ends |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe for both byte lanes, active low |
| ready | output | 1 | Device initialised and refresh deadline kept |
| hostOk | output | 1 | Host request accepted |
| deadMiss | output | 1 | One-cycle pulse when the refresh deadline is missed |

## Verification
The timing of every result is fixed by registers. `ready` rises on the edge that retires the last wake-up refresh. A slot expiry becomes visible on `refReq` one edge after the backlog counts it, and `deadMiss` is seen in the cycle before `ready` falls. The bench counts clock edges from reset release and samples on falling edges exactly at the cycle numbers derived from those latencies. Strobe pulse widths and setup and hold runs are measured continuously by a monitor that counts consecutive samples and checks each one when a strobe edge occurs.

// File: rtl/refresh_seq_pkg.sv
package refresh_seq_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE, ST_IDLE, ST_REQ, ST_SETUP, ST_CHOLD, ST_RLOW, ST_PRE
  } seqState_t;

  typedef enum logic [1:0] {
    PH_SETUP, PH_CHOLD, PH_RLOW, PH_PRE
  } phase_t;

  typedef struct packed {
    logic   phaseLoad;
    phase_t phaseSel;
    logic   cycleDone;
  } seqStrobe_t;

endpackage

// File: rtl/refresh_seq_dp.sv
module refresh_seq_dp
  import refresh_seq_pkg::*;
#(
  parameter int PAUSE_CYC   = 50000,
  parameter int SLOT_CYC    = 3906,
  parameter int CSR_CYC     = 3,
  parameter int CHR_CYC     = 3,
  parameter int RAS_CYC     = 15,
  parameter int RP_CYC      = 10,
  parameter int WAKE_NUM    = 8,
  parameter int BACKLOG_MAX = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       pauseDone,
  output logic       phaseZero,
  output logic       workPending,
  output logic       ready,
  output logic       deadMiss
);
  localparam int PW  = $clog2(PAUSE_CYC);
  localparam int SW  = $clog2(SLOT_CYC);
  localparam int BW  = $clog2(BACKLOG_MAX + 1);
  localparam int WW  = $clog2(WAKE_NUM + 1);
  localparam int PHW = $clog2(CSR_CYC + CHR_CYC + RAS_CYC + RP_CYC + 1);

  logic [PW-1:0]  pauseCnt;
  logic [SW-1:0]  slotCnt;
  logic [BW-1:0]  backlog;
  logic [WW-1:0]  wakeLeft;
  logic [PHW-1:0] phaseCnt;
  logic [PHW-1:0] phaseInit;
  logic           slotTick;
  logic           drainOne;

  assign pauseDone   = (pauseCnt == '0);
  assign ready       = pauseDone && (wakeLeft == '0);
  assign slotTick    = ready && (slotCnt == '0);
  assign deadMiss    = slotTick && (backlog == BW'(BACKLOG_MAX));
  assign drainOne    = strobe.cycleDone && (wakeLeft == '0);
  assign workPending = pauseDone && ((wakeLeft != '0) || (backlog != '0));
  assign phaseZero   = (phaseCnt == '0);

  always_comb begin
    unique case (strobe.phaseSel)
      PH_SETUP: phaseInit = PHW'(CSR_CYC - 1);
      PH_CHOLD: phaseInit = PHW'(CHR_CYC - 1);
      PH_RLOW:  phaseInit = PHW'(RAS_CYC - CHR_CYC - 1);
      default:  phaseInit = PHW'(RP_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) pauseCnt <= PW'(PAUSE_CYC - 1);
    else if (!pauseDone) pauseCnt <= pauseCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !ready || slotTick) slotCnt <= SW'(SLOT_CYC - 1);
    else slotCnt <= slotCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      backlog  <= '0;
      wakeLeft <= WW'(WAKE_NUM);
    end else if (deadMiss) begin
      backlog  <= '0;
      wakeLeft <= WW'(WAKE_NUM);
    end else begin
      if (strobe.cycleDone && wakeLeft != '0) wakeLeft <= wakeLeft - 1'b1;
      if (slotTick && !drainOne) backlog <= backlog + 1'b1;
      else if (!slotTick && drainOne && backlog != '0) backlog <= backlog - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phaseCnt <= '0;
    else if (strobe.phaseLoad) phaseCnt <= phaseInit;
    else if (!phaseZero) phaseCnt <= phaseCnt - 1'b1;
  end

  AST_BACKLOG_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    backlog <= BW'(BACKLOG_MAX)); // R7
  AST_MISS_RELOADS_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    deadMiss |=> (!ready && wakeLeft == WW'(WAKE_NUM) && backlog == '0)); // R8
  AST_TIMER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!ready) |=> (slotCnt == SW'(SLOT_CYC - 1))); // R10

endmodule

// File: rtl/refresh_seq_ctrl.sv
module refresh_seq_ctrl
  import refresh_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refGnt,
  input  logic       pauseDone,
  input  logic       phaseZero,
  input  logic       workPending,
  output seqStrobe_t strobe,
  output logic       refReq,
  output logic       rasN,
  output logic       casN
);
  seqState_t state, nextState;

  always_comb begin
    nextState        = state;
    strobe.phaseLoad = 1'b0;
    strobe.phaseSel  = PH_SETUP;
    strobe.cycleDone = 1'b0;
    unique case (state)
      ST_PAUSE: if (pauseDone) nextState = ST_IDLE;
      ST_IDLE:  if (workPending) nextState = ST_REQ;
      ST_REQ:
        if (refGnt) begin
          nextState        = ST_SETUP;
          strobe.phaseLoad = 1'b1;
          strobe.phaseSel  = PH_SETUP;
        end
      ST_SETUP:
        if (phaseZero) begin
          nextState        = ST_CHOLD;
          strobe.phaseLoad = 1'b1;
          strobe.phaseSel  = PH_CHOLD;
        end
      ST_CHOLD:
        if (phaseZero) begin
          nextState        = ST_RLOW;
          strobe.phaseLoad = 1'b1;
          strobe.phaseSel  = PH_RLOW;
        end
      ST_RLOW:
        if (phaseZero) begin
          nextState        = ST_PRE;
          strobe.phaseLoad = 1'b1;
          strobe.phaseSel  = PH_PRE;
        end
      default:
        if (phaseZero) begin
          nextState        = ST_IDLE;
          strobe.cycleDone = 1'b1;
        end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_PAUSE;
    else state <= nextState;
  end

  assign refReq = (state != ST_PAUSE) && (state != ST_IDLE);
  assign casN   = !((state == ST_SETUP) || (state == ST_CHOLD));
  assign rasN   = !((state == ST_CHOLD) || (state == ST_RLOW));

  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && $past(!casN))); // R2
  AST_CAS_FALLS_RAS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> rasN); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refGnt) |=> refReq); // R3
  AST_RAS_RISE_CAS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> casN); // R4

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import refresh_seq_pkg::*;
#(
  parameter int PAUSE_CYC   = 50000,
  parameter int SLOT_CYC    = 3906,
  parameter int CSR_CYC     = 3,
  parameter int CHR_CYC     = 3,
  parameter int RAS_CYC     = 15,
  parameter int RP_CYC      = 10,
  parameter int WAKE_NUM    = 8,
  parameter int BACKLOG_MAX = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGnt,
  input  logic hostReq,
  output logic refReq,
  output logic rasN,
  output logic casN,
  output logic ready,
  output logic hostOk,
  output logic deadMiss
);
  seqStrobe_t strobe;
  logic pauseDone, phaseZero, workPending;

  refresh_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .refGnt(refGnt), .pauseDone(pauseDone),
    .phaseZero(phaseZero), .workPending(workPending), .strobe(strobe),
    .refReq(refReq), .rasN(rasN), .casN(casN)
  );

  refresh_seq_dp #(
    .PAUSE_CYC(PAUSE_CYC), .SLOT_CYC(SLOT_CYC), .CSR_CYC(CSR_CYC),
    .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC),
    .WAKE_NUM(WAKE_NUM), .BACKLOG_MAX(BACKLOG_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pauseDone(pauseDone),
    .phaseZero(phaseZero), .workPending(workPending), .ready(ready),
    .deadMiss(deadMiss)
  );

  assign hostOk = hostReq && ready;

  AST_HOST_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !ready) |-> !hostOk); // R9

endmodule

// File: tb/refresh_seq_bench.sv
module refresh_seq_bench;
  localparam int P   = 40;
  localparam int S   = 80;
  localparam int CSR = 2;
  localparam int CHR = 3;
  localparam int RAS = 6;
  localparam int RP  = 4;
  localparam int WK  = 8;
  localparam int BMX = 3;
  localparam int L   = CSR + RAS + RP + 2;
  localparam int E   = P + WK * L;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoGnt = 1'b1;
  logic hostReq = 1'b1;
  logic refGnt;
  logic refReq, rasN, casN, ready, hostOk, deadMiss;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rasFalls = 0;
  int preRun = 0, holdRun = 0, lowRun = 0, idleRun = 100;
  logic prevRas = 1'b1, prevCas = 1'b1, gotGnt = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign refGnt = autoGnt && refReq;

  refresh_seq #(
    .PAUSE_CYC(P), .SLOT_CYC(S), .CSR_CYC(CSR), .CHR_CYC(CHR),
    .RAS_CYC(RAS), .RP_CYC(RP), .WAKE_NUM(WK), .BACKLOG_MAX(BMX)
  ) u_refresh_seq (
    .clk(clk), .rstN(rstN), .refGnt(refGnt), .hostReq(hostReq),
    .refReq(refReq), .rasN(rasN), .casN(casN), .ready(ready),
    .hostOk(hostOk), .deadMiss(deadMiss)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else cyc <= cyc + 1;
  end

  // strobe monitor: pulse widths and ordering
  always @(negedge clk) begin
    if (rstN) begin
      if (prevRas && !rasN) begin
        rasFalls++;
        chk(preRun == CSR, "R2 cas setup before ras", preRun, CSR);
      end
      if (!prevCas && casN && !rasN)
        chk(holdRun == CHR, "R2 cas hold after ras", holdRun, CHR);
      if (!prevRas && rasN)
        chk(lowRun == RAS, "R4 ras low width", lowRun, RAS);
      if (prevCas && !casN) begin
        chk(rasN == 1'b1, "R2 cas falls with ras high", int'(rasN), 1);
        chk(idleRun >= RP, "R4 precharge before cas", idleRun, RP);
        chk(gotGnt == 1'b1, "R3 strobe only after grant", int'(gotGnt), 1);
      end
      if (refReq && refGnt) gotGnt = 1'b1;
      else if (!refReq) gotGnt = 1'b0;
      preRun  = (!casN && rasN)  ? preRun + 1  : 0;
      holdRun = (!casN && !rasN) ? holdRun + 1 : 0;
      lowRun  = (!rasN)          ? lowRun + 1  : 0;
      idleRun = (casN && rasN)   ? idleRun + 1 : 0;
      prevRas = rasN;
      prevCas = casN;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rasN == 1'b1 && casN == 1'b1, "R1 strobes high in reset", int'({rasN, casN}), 3);
    chk(refReq == 1'b0, "R1 no request in reset", int'(refReq), 0);
    chk(ready == 1'b0 && hostOk == 1'b0, "R1 not ready in reset", int'({ready, hostOk}), 0);
    chk(deadMiss == 1'b0, "R1 no miss in reset", int'(deadMiss), 0);
    rstN = 1'b1;

    waitCyc(20);
    chk(hostOk == 1'b0, "R9 host refused during pause", int'(hostOk), 0);
    waitCyc(P - 1);
    chk(rasFalls == 0, "R5 no strobes during pause", rasFalls, 0);
    waitCyc(E - 1);
    chk(ready == 1'b0, "R5 ready not early", int'(ready), 0);
    waitCyc(E);
    chk(ready == 1'b1, "R5 ready on time", int'(ready), 1);
    chk(rasFalls == WK, "R5 wake-up pulse count", rasFalls, WK);
    chk(hostOk == 1'b1, "R9 host accepted when ready", int'(hostOk), 1);

    waitCyc(E + S);
    chk(refReq == 1'b0, "R6 request not early", int'(refReq), 0);
    waitCyc(E + S + 1);
    chk(refReq == 1'b1, "R10 R6 first slot request", int'(refReq), 1);
    waitCyc(E + S + 30);
    chk(rasFalls == WK + 1, "R6 one refresh per slot", rasFalls, WK + 1);

    // withhold grant until the deadline is missed
    waitCyc(300);
    autoGnt = 1'b0;
    waitCyc(320);
    chk(refReq == 1'b1, "R3 request held without grant", int'(refReq), 1);
    chk(rasN == 1'b1 && casN == 1'b1, "R3 strobes idle without grant", int'({rasN, casN}), 3);
    waitCyc(E + 5 * S - 2);
    chk(deadMiss == 1'b0 && ready == 1'b1, "R8 no miss before full backlog", int'({deadMiss, ready}), 1);
    waitCyc(E + 5 * S - 1);
    chk(deadMiss == 1'b1, "R8 miss pulse", int'(deadMiss), 1);
    chk(rasFalls == WK + 1, "R3 no refresh without grant", rasFalls, WK + 1);
    waitCyc(E + 5 * S);
    chk(deadMiss == 1'b0, "R8 miss is one cycle", int'(deadMiss), 0);
    chk(ready == 1'b0 && hostOk == 1'b0, "R8 R9 ready dropped", int'({ready, hostOk}), 0);

    waitCyc(560);
    autoGnt = 1'b1;
    waitCyc(561 + CSR + RAS + RP + (WK - 1) * L - 1);
    chk(ready == 1'b0, "R8 wake-up repeated", int'(ready), 0);
    waitCyc(561 + CSR + RAS + RP + (WK - 1) * L);
    chk(ready == 1'b1, "R8 ready after repeat", int'(ready), 1);
    chk(rasFalls == 2 * WK + 1, "R8 repeated pulse count", rasFalls, 2 * WK + 1);

    // backlog of two slots then drain
    waitCyc(680);
    autoGnt = 1'b0;
    waitCyc(840);
    chk(rasFalls == 2 * WK + 1, "R7 backlog held", rasFalls, 2 * WK + 1);
    waitCyc(845);
    autoGnt = 1'b1;
    waitCyc(880);
    chk(rasFalls == 2 * WK + 3, "R7 backlog drained back to back", rasFalls, 2 * WK + 3);
    chk(refReq == 1'b0, "R7 request released after drain", int'(refReq), 0);
    chk(ready == 1'b1, "R7 ready kept under backlog", int'(ready), 1);
    hostReq = 1'b0;
    waitCyc(881);
    chk(hostOk == 1'b0, "R9 no accept without request", int'(hostOk), 0);
    waitCyc(911);
    chk(refReq == 1'b0, "R6 slot spacing kept", int'(refReq), 0);
    waitCyc(912);
    chk(refReq == 1'b1, "R6 next slot request", int'(refReq), 1);
    waitCyc(950);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d: actual=%0d expected=%0d", cyc, 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule